// File: doc/BRIEF.md
# ALC gain step timing controller

This block produces the step-enable pulses that pace an automatic level control loop. It counts ticks that arrive at twice the audio sample rate, so a half-sample interval is one tick and all longer intervals are whole numbers of ticks. A limiter-event input is asserted while the signal sits above its threshold. While it is high, the block emits limiter step pulses at a programmable interval. Once the input has been low for a programmable quiet period, the block emits recovery step pulses. Every limiter event restarts that quiet period.

A second, free-running recovery timer paces another level-control path on its own. A single 8-bit configuration register holds the selectors. Gain arithmetic, threshold comparison and zero-crossing handling sit outside the block. The zero-cross timeout code is only stored here for the neighbour that uses it.

Top module: `alc_step_timer`

## Requirements
- R1: After reset the register reads 0x00 and all three step outputs are low.
- R2: A write stores wdata[6:0], and the register reads back {0, stored[6:0]}. Bit 7 always reads 0. The fields are: [1:0] limiter interval code, [3:2] recovery wait code, [5:4] zero-cross timeout code (stored only), [6] second-path period select.
- R3: The limiter interval is 1, 2, 4 or 8 ticks for codes 0, 1, 2 and 3. The interval counter reloads on the cycle the limiter event first asserts. While the event stays high, `lim_step_o` pulses after each full interval of ticks.
- R4: No limiter step pulse follows a cycle in which the limiter event was low.
- R5: The recovery wait is 256 << code ticks. With the event low, `rcv_step_o` pulses once the wait has elapsed since the last event-high cycle, and again after each further wait.
- R6: Any event-high cycle restarts the recovery wait. No recovery pulse follows such a cycle, even when the wait expires in that same cycle.
- R7: `rcv2_step_o` pulses every 4096 ticks when bit 6 is 0 and every 1024 ticks when it is 1. The limiter event has no effect on it. The first period after reset is 4096 ticks.
- R8: Each step pulse follows a clock edge at which `tick_i` was high. A pulse lasts one cycle.
- R9: A new interval code takes effect only at the next reload of its counter. A countdown already running finishes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle tick at twice the sample rate |
| lim_evt_i | input | 1 | Signal above limiter threshold |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| lim_step_o | output | 1 | Limiter step enable pulse |
| rcv_step_o | output | 1 | Recovery step enable pulse |
| rcv2_step_o | output | 1 | Second-path recovery step enable pulse |

## Verification
The contested cycle is the one where the recovery wait runs out at the same edge that a limiter event arrives. The restart must win, and no recovery pulse may appear. The bench provokes this by pulsing the event with gaps swept a few cycles either side of twice the wait. That sweep makes expiry and event land on the same edge under both tick phases. An independent tick-counting monitor judges every pulse and every missing pulse against the interval expected from the register value held at the last reload.

// File: rtl/alc_step_pkg.sv
package alc_step_pkg;
  typedef struct packed {
    logic       rcv2_short;
    logic [1:0] zc_code;
    logic [1:0] rcv_code;
    logic [1:0] lim_code;
  } tmr_cfg_t;

  localparam int N_CH  = 3;
  localparam int CH_LIM  = 0;
  localparam int CH_RCV  = 1;
  localparam int CH_RCV2 = 2;
endpackage

// File: rtl/alc_step_regs.sv
module alc_step_regs
  import alc_step_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [1:0] lim_code_o,
  output logic [1:0] rcv_code_o,
  output logic       rcv2_short_o
);
  tmr_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= tmr_cfg_t'(wdata_i[6:0]);
  end

  assign rdata_o      = {1'b0, cfg_q};
  assign lim_code_o   = cfg_q.lim_code;
  assign rcv_code_o   = cfg_q.rcv_code;
  assign rcv2_short_o = cfg_q.rcv2_short;
endmodule

// File: rtl/alc_step_cnt.sv
module alc_step_cnt #(
  parameter int CW      = 13,
  parameter int RST_VAL = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          en_i,
  input  logic [CW-1:0] reload_i,
  output logic          stb_o
);
  logic [CW-1:0] cnt_q;

  // load wins over an expiry in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(RST_VAL);
      stb_o <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (load_i) begin
        cnt_q <= reload_i;
      end else if (en_i) begin
        if (cnt_q <= CW'(1)) begin
          stb_o <= 1'b1;
          cnt_q <= reload_i;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer
  import alc_step_pkg::*;
#(
  parameter int LIM_BASE   = 1,
  parameter int RCV_BASE   = 256,
  parameter int RCV2_LONG  = 4096,
  parameter int RCV2_SHORT = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       lim_evt_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       lim_step_o,
  output logic       rcv_step_o,
  output logic       rcv2_step_o
);
  localparam int LIM_MAX = LIM_BASE << 3;
  localparam int RCV_MAX = RCV_BASE << 3;
  localparam int MAX_A   = (LIM_MAX > RCV_MAX) ? LIM_MAX : RCV_MAX;
  localparam int MAX_V   = (MAX_A > RCV2_LONG) ? MAX_A : RCV2_LONG;
  localparam int CW      = $clog2(MAX_V + 1);

  logic [1:0] lim_code, rcv_code;
  logic       rcv2_short;
  logic       evt_q;

  logic [N_CH-1:0] load, en, stb;
  logic [CW-1:0]   reload [N_CH];

  alc_step_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .lim_code_o   (lim_code),
    .rcv_code_o   (rcv_code),
    .rcv2_short_o (rcv2_short)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= lim_evt_i;
  end

  always_comb begin
    load[CH_LIM]    = lim_evt_i & ~evt_q;
    en[CH_LIM]      = tick_i & lim_evt_i;
    reload[CH_LIM]  = CW'(LIM_BASE) << lim_code;
    load[CH_RCV]    = lim_evt_i;
    en[CH_RCV]      = tick_i & ~lim_evt_i;
    reload[CH_RCV]  = CW'(RCV_BASE) << rcv_code;
    load[CH_RCV2]   = 1'b0;
    en[CH_RCV2]     = tick_i;
    reload[CH_RCV2] = rcv2_short ? CW'(RCV2_SHORT) : CW'(RCV2_LONG);
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int RV = (i == CH_LIM) ? LIM_BASE :
                        (i == CH_RCV) ? RCV_BASE : RCV2_LONG;
    alc_step_cnt #(.CW(CW), .RST_VAL(RV)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load[i]),
      .en_i     (en[i]),
      .reload_i (reload[i]),
      .stb_o    (stb[i])
    );
  end

  assign lim_step_o  = stb[CH_LIM];
  assign rcv_step_o  = stb[CH_RCV];
  assign rcv2_step_o = stb[CH_RCV2];
endmodule

// File: rtl/alc_step_chk.sv
module alc_step_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       lim_evt_i,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       lim_step_o,
  input logic       rcv_step_o,
  input logic       rcv2_step_o
);
  AST_LIM_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_step_o |-> $past(lim_evt_i)); // R4
  AST_RCV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_step_o |-> !$past(lim_evt_i)); // R6
  AST_STB_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_step_o | rcv_step_o | rcv2_step_o) |-> $past(tick_i)); // R8
  AST_RCV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_step_o |=> !rcv_step_o); // R8
  AST_RCV2_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv2_step_o |=> !rcv2_step_o); // R7
  AST_WR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == {1'b0, $past(reg_wdata_i[6:0])}); // R2
endmodule

bind alc_step_timer alc_step_chk u_chk (.*);

// File: tb/alc_step_timer_tb_top.sv
`timescale 1ns/1ps
module alc_step_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, evt = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic lim_stb, rcv_stb, rcv2_stb;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alc_step_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .lim_evt_i(evt),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .lim_step_o(lim_stb), .rcv_step_o(rcv_stb), .rcv2_step_o(rcv2_stb)
  );

  function automatic int lim_n(logic [1:0] c);  return 1 << c;       endfunction
  function automatic int rcv_w(logic [1:0] c);  return 256 << c;     endfunction
  function automatic int p2(logic b);           return b ? 1024 : 4096; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // edge-side capture: values the design saw at each clock edge
  int tick_cnt;
  logic evt_q, evt_e, rise_e;
  logic [6:0] reg_m, reg_e;
  always @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= 0; evt_q <= 0; evt_e <= 0; rise_e <= 0; reg_m <= '0; reg_e <= '0;
    end else begin
      tick_cnt <= tick_cnt + int'(tick);
      evt_e    <= evt;
      rise_e   <= evt && !evt_q;
      evt_q    <= evt;
      reg_e    <= reg_m;
      if (we) reg_m <= wdata[6:0];
    end
  end

  // tick-counting monitor
  int lim_ref, lim_exp, rcv_ref, rcv_exp, r2_ref, r2_exp;
  int n_lim = 0, n_rcv = 0, n_rcv2 = 0, n_r9 = 0, n_long = 0, n_short = 0, n_r8 = 0;
  logic lim_p, rcv_p, r2_p;
  always @(negedge clk) begin
    if (!rst_n) begin
      lim_ref = 0; lim_exp = 1; rcv_ref = 0; rcv_exp = 256; r2_ref = 0; r2_exp = 4096;
      lim_p = 0; rcv_p = 0; r2_p = 0;
    end else begin
      automatic int t = tick_cnt;
      if ((lim_stb && lim_p) || (rcv_stb && rcv_p) || (rcv2_stb && r2_p)) begin
        n_r8++; chk(0, "R8 pulse width", 2, 1);
      end
      lim_p = lim_stb; rcv_p = rcv_stb; r2_p = rcv2_stb;
      // limiter
      if (lim_stb) begin
        n_lim++;
        chk(evt_e, "R4 strobe without event", 0, 1);
        if (lim_exp != lim_n(reg_m[1:0])) begin
          n_r9++; chk(t - lim_ref == lim_exp, "R9 old interval kept", t - lim_ref, lim_exp);
        end else chk(t - lim_ref == lim_exp, "R3 limiter interval", t - lim_ref, lim_exp);
        lim_ref = t; lim_exp = lim_n(reg_e[1:0]);
      end else if (rise_e) begin
        lim_ref = t; lim_exp = lim_n(reg_e[1:0]);
      end else if (evt_e && (t - lim_ref > lim_exp)) begin
        chk(0, "R3 missing limiter strobe", t - lim_ref, lim_exp);
        lim_ref = t;
      end
      // recovery
      if (evt_e) begin
        if (rcv_stb) chk(0, "R6 recovery during event", 1, 0);
        rcv_ref = t; rcv_exp = rcv_w(reg_e[3:2]);
      end else if (rcv_stb) begin
        n_rcv++;
        chk(t - rcv_ref == rcv_exp, "R5 recovery wait", t - rcv_ref, rcv_exp);
        rcv_ref = t; rcv_exp = rcv_w(reg_e[3:2]);
      end else if (t - rcv_ref > rcv_exp) begin
        chk(0, "R5 missing recovery strobe", t - rcv_ref, rcv_exp);
        rcv_ref = t;
      end
      // second path
      if (rcv2_stb) begin
        n_rcv2++;
        if (r2_exp == 4096) n_long++; else n_short++;
        chk(t - r2_ref == r2_exp, "R7 second path period", t - r2_ref, r2_exp);
        r2_ref = t; r2_exp = p2(reg_e[6]);
      end else if (t - r2_ref > r2_exp) begin
        chk(0, "R7 missing second path strobe", t - r2_ref, r2_exp);
        r2_ref = t;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    tick = rst_n ? ~tick : 1'b0;
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic pulse_evt();
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
  endtask

  initial begin
    int snap;
    cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 8'h00, "R1 reset rdata", rdata, 0);
    chk(!lim_stb, "R1 reset lim", lim_stb, 0);
    chk(!rcv_stb, "R1 reset rcv", rcv_stb, 0);
    chk(!rcv2_stb, "R1 reset rcv2", rcv2_stb, 0);

    // R2: every write value
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      chk(rdata == {1'b0, 7'(v)}, "R2 readback", rdata, v & 8'h7f);
    end
    wr(8'h00);

    // R3: each limiter code
    for (int c = 0; c < 4; c++) begin
      wr(8'(c));
      snap = n_lim;
      @(negedge clk); evt = 1'b1;
      cyc(2 * 8 * 5 + 3);
      evt = 1'b0;
      cyc(10);
      chk(n_lim - snap >= 4, "R3 limiter strobes seen", n_lim - snap, 4);
    end

    // R4: event low
    snap = n_lim;
    cyc(300);
    chk(n_lim == snap, "R4 no strobe while idle", n_lim - snap, 0);

    // R9: code change mid-interval
    wr(8'h03);
    @(negedge clk); evt = 1'b1;
    cyc(6);
    wr(8'h00);
    cyc(40);
    evt = 1'b0;
    cyc(4);
    chk(n_r9 >= 1, "R9 reload-time update observed", n_r9, 1);

    // R5: each recovery code
    for (int c = 0; c < 4; c++) begin
      wr(8'(c << 2));
      pulse_evt();
      snap = n_rcv;
      cyc(4 * rcv_w(2'(c)) + 20);
      chk(n_rcv - snap == 2, "R5 recovery count", n_rcv - snap, 2);
    end

    // R6: events closer than the wait
    wr(8'h00);
    pulse_evt();
    snap = n_rcv;
    for (int k = 0; k < 5; k++) begin
      cyc(500);
      pulse_evt();
    end
    chk(n_rcv == snap, "R6 restart suppresses recovery", n_rcv - snap, 0);
    // R6: event lands around expiry
    for (int g = 2 * 256 - 6; g <= 2 * 256 + 6; g++) begin
      pulse_evt();
      cyc(g);
    end
    pulse_evt();
    cyc(4);

    // R7: short period, event has no effect
    wr(8'h40);
    snap = n_short;
    evt = 1'b1;
    cyc(2 * 4096 + 2 * 1024 * 2 + 50);
    evt = 1'b0;
    chk(n_short - snap >= 2, "R7 short period seen", n_short - snap, 2);
    chk(n_long >= 1, "R7 long period seen", n_long, 1);
    wr(8'h00);
    cyc(10);

    chk(n_r8 == 0, "R8 no wide pulses", n_r8, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule